// File: doc/BRIEF.md
# Chained Four-Channel DMA Register Engine

This block is the register and sequencing core of a four-channel bus-master DMA engine. Each channel keeps two descriptors. The active one is a current word address and a remaining-word count that the channel is working through. The queued one is a next address and next count that software loads through a small 32-bit register port. A separate data mover, outside this block, does the bus work and pulses one strobe per channel for each 32-bit word it moves. The block steps the active descriptor on each strobe. It exposes the current address, the direction and a busy flag for every channel.

When the last word of an active transfer is moved and a queued descriptor is waiting, the block promotes that descriptor into the active registers on the same clock edge. The channel then continues with no gap and with no help from software. An end-of-transfer event sets a sticky per-channel flag if that channel's interrupt enable is on. One shared interrupt line is the OR of those flags. Each channel's data direction is fixed in hardware. The two lower channels always write host memory, and the two upper channels always read it.

Top module: `dma4_chain_regs`

## Requirements
- R1: After reset, every address, count, enable, pending and interrupt flag is zero, `irq` is low and `ch_busy` is all zero.
- R2: Register offset = 0x10 × channel + register. Register 0x0 is the current address (read-only). Register 0x4 is the next address (read/write). Register 0x8 is the current word count (read-only). Register 0xC is control plus next count. Writes to read-only registers are ignored.
- R3: Bits 1:0 of every address and count read as zero. Bits 31:20 of the count registers read as zero. Bits 19:2 hold a word count of up to 2^18 − 1. Address bits 31:20 select a 1 MB page.
- R4: Control bit 29 enables the channel. Bit 27 enables its end-of-transfer interrupt. Bit 31 reads back the shared `irq` line. Bits 30, 28, 26 and 24:20 read as zero.
- R5: Control bit 25 (1 = read host memory) always reads 0 on channels 0 and 1 and reads 1 on channels 2 and 3, whatever value is written. `ch_dir_read` shows the same values.
- R6: A write to control/next-count marks the next descriptor pending. If the channel is enabled and its current count is zero, the pending descriptor is loaded into the current registers at the next clock edge and the pending mark clears.
- R7: A channel is busy while it is enabled and its current count is nonzero. Each strobe on a busy channel adds 4 to the byte address, with carry into the page bits, and subtracts 1 from the count.
- R8: A strobe on a channel that is not busy leaves its address and count unchanged.
- R9: When the strobe moves the last word and a descriptor is pending, the next address and count become current on that same edge. The channel stays busy if the new count is nonzero.
- R10: When the last word is moved with nothing pending, the count reads zero and the channel goes idle.
- R11: The last word with interrupt enable set raises the channel's sticky flag. `irq` is the OR of all set flags, and control bit 31 follows `irq`.
- R12: The last word with interrupt enable clear raises no flag.
- R13: A write to a channel's control register clears that channel's interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset (channel in bits 5:4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| word_strobe | input | 4 | One word moved, one bit per channel |
| ch_busy | output | 4 | Channel is enabled and has words left |
| ch_dir_read | output | 4 | Fixed direction per channel (1 = read host) |
| ch_word_addr | output | 120 | Current word address (byte address bits 31:2), 30 bits per channel |
| irq | output | 1 | Shared end-of-transfer interrupt |

## Verification
The main function is tested with several stimulus patterns.

1. A three-word transfer that starts just below a 1 MB boundary. This separates a correct page carry from an address that wraps inside the page.
2. A descriptor queued while a transfer is running. Its promotion on the last strobe separates seamless chaining from a one-cycle gap or a lost descriptor.
3. Strobes sent to a disabled channel and to an idle channel. These separate gated stepping from unconditional stepping.
4. A finishing transfer with the interrupt enable on, and another with it off, followed by a control write. These separate sticky, enable-gated flags from flags that are raised unconditionally or are never cleared.

// File: rtl/dma4_chain_regs.sv
module dma4_chain_regs #(
  parameter int NCH = 4,
  parameter int CW  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    word_strobe,
  output logic [NCH-1:0]    ch_busy,
  output logic [NCH-1:0]    ch_dir_read,
  output logic [NCH*30-1:0] ch_word_addr,
  output logic              irq
);
  localparam int CHW = 2;
  localparam int PADW = 18 - CW;

  logic [NCH-1:0][29:0]   cur_a, nxt_a;
  logic [NCH-1:0][CW-1:0] cur_c, nxt_c;
  logic [NCH-1:0]         en_q, ien_q, pend_q, flag_q;

  wire [CHW-1:0] sel_ch  = reg_addr[5:4];
  wire [1:0]     sel_reg = reg_addr[3:2];

  assign irq = |flag_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wire hit     = reg_wr && (sel_ch == CHW'(g));
    wire wr_na   = hit && (sel_reg == 2'd1);
    wire wr_ct   = hit && (sel_reg == 2'd3);
    wire busy    = en_q[g] && (cur_c[g] != '0);
    wire step    = busy && word_strobe[g];
    wire last    = step && (cur_c[g] == CW'(1));
    wire promote = pend_q[g] && en_q[g] && ((cur_c[g] == '0) || last);

    assign ch_busy[g]               = busy;
    assign ch_dir_read[g]           = (g >= NCH / 2);
    assign ch_word_addr[g*30 +: 30] = cur_a[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur_a[g]  <= '0;
        nxt_a[g]  <= '0;
        cur_c[g]  <= '0;
        nxt_c[g]  <= '0;
        en_q[g]   <= 1'b0;
        ien_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
        flag_q[g] <= 1'b0;
      end else begin
        if (wr_na) nxt_a[g] <= reg_wdata[31:2];
        if (wr_ct) begin
          nxt_c[g] <= reg_wdata[CW+1:2];
          en_q[g]  <= reg_wdata[29];
          ien_q[g] <= reg_wdata[27];
        end
        if (wr_ct)        pend_q[g] <= 1'b1;
        else if (promote) pend_q[g] <= 1'b0;
        if (promote) begin
          cur_a[g] <= nxt_a[g];
          cur_c[g] <= nxt_c[g];
        end else if (step) begin
          cur_a[g] <= cur_a[g] + 30'd1;
          cur_c[g] <= cur_c[g] - CW'(1);
        end
        if (last && ien_q[g]) flag_q[g] <= 1'b1;
        else if (wr_ct)       flag_q[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel_reg)
      2'd0: reg_rdata = {cur_a[sel_ch], 2'b00};
      2'd1: reg_rdata = {nxt_a[sel_ch], 2'b00};
      2'd2: reg_rdata = {12'd0, {PADW{1'b0}}, cur_c[sel_ch], 2'b00};
      default: reg_rdata = {irq, 1'b0, en_q[sel_ch], 1'b0, ien_q[sel_ch], 1'b0,
                            ch_dir_read[sel_ch], 5'd0, {PADW{1'b0}},
                            nxt_c[sel_ch], 2'b00};
    endcase
  end
endmodule

// File: rtl/dma4_chain_regs_chk.sv
module dma4_chain_regs_chk #(
  parameter int NCH = 4,
  parameter int CW  = 18
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         word_strobe,
  input logic [NCH-1:0]         en_q,
  input logic [NCH-1:0]         ien_q,
  input logic [NCH-1:0]         pend_q,
  input logic [NCH-1:0]         flag_q,
  input logic [NCH-1:0][29:0]   cur_a,
  input logic [NCH-1:0][29:0]   nxt_a,
  input logic [NCH-1:0][CW-1:0] cur_c,
  input logic                   irq
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[g] && word_strobe[g] && cur_c[g] > CW'(1)) |=> cur_c[g] == $past(cur_c[g]) - CW'(1)); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[g] && word_strobe[g] && cur_c[g] > CW'(1)) |=> cur_a[g] == $past(cur_a[g]) + 30'd1); // R7
    AST_CHAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[g] && pend_q[g] && word_strobe[g] && cur_c[g] == CW'(1)) |=> cur_a[g] == $past(nxt_a[g])); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(en_q[g] && cur_c[g] != '0) && !(en_q[g] && pend_q[g])) |=> $stable(cur_c[g]) && $stable(cur_a[g])); // R8
    AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[g]) |-> $past(ien_q[g])); // R12
  end
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != '0) |-> irq); // R11
endmodule

bind dma4_chain_regs dma4_chain_regs_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_strobe(word_strobe), .en_q(en_q),
  .ien_q(ien_q), .pend_q(pend_q), .flag_q(flag_q), .cur_a(cur_a),
  .nxt_a(nxt_a), .cur_c(cur_c), .irq(irq)
);

// File: tb/dma4_chain_regs_tb.sv
module dma4_chain_regs_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [5:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [3:0]   word_strobe = '0;
  logic [3:0]   ch_busy, ch_dir_read;
  logic [119:0] ch_word_addr;
  logic         irq;

  dma4_chain_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .word_strobe(word_strobe),
    .ch_busy(ch_busy), .ch_dir_read(ch_dir_read), .ch_word_addr(ch_word_addr),
    .irq(irq)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          kind;
    logic [5:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  go;
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always begin
    @(go);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = {31'd0, irq};
        2: act = {28'd0, ch_busy};
        3: act = {28'd0, ch_dir_read};
        default: act = {ch_word_addr[it.a*30 +: 30], 2'b00};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int kind, input logic [5:0] a,
                             input logic [31:0] exp, input string tag);
    item_t it;
    if (kind == 0) reg_addr = a;
    it.kind = kind; it.a = a; it.exp = exp; it.tag = tag;
    q.push_back(it);
    -> go;
    #2;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic strobe(input int ch, input int n);
    @(negedge clk);
    word_strobe = 4'(1 << ch);
    repeat (n) @(negedge clk);
    word_strobe = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_item(0, 6'h0C, 32'h0000_0000, "R1 ch0 ctrl after reset");
    expect_item(0, 6'h18, 32'h0000_0000, "R1 ch1 count after reset");
    expect_item(1, 0, 32'd0, "R1 irq after reset");
    expect_item(2, 0, 32'd0, "R1 busy after reset");
    expect_item(0, 6'h2C, 32'h0200_0000, "R5 ch2 fixed read direction");

    wr(6'h0C, 32'h0200_0000);
    wr(6'h3C, 32'h0000_0000);
    expect_item(0, 6'h0C, 32'h0000_0000, "R5 ch0 direction forced low");
    expect_item(0, 6'h3C, 32'h0200_0000, "R5 ch3 direction forced high");
    expect_item(3, 0, 32'h0000_000C, "R5 dir outputs");

    wr(6'h14, 32'h1234_5677);
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h10, 32'hFFFF_FFFF);
    expect_item(0, 6'h14, 32'h1234_5674, "R2 R3 ch1 next address low bits");
    expect_item(0, 6'h18, 32'h0000_0000, "R2 ch1 count write ignored");
    expect_item(0, 6'h10, 32'h0000_0000, "R2 ch1 current address write ignored");
    wr(6'h1C, 32'hDFFF_FFFF);
    expect_item(0, 6'h1C, 32'h080F_FFFC, "R4 R3 ch1 control readback");

    wr(6'h04, 32'h000F_FFF8);
    wr(6'h0C, 32'h2800_000C);
    @(negedge clk);
    expect_item(0, 6'h00, 32'h000F_FFF8, "R6 ch0 address loaded");
    expect_item(0, 6'h08, 32'h0000_000C, "R6 ch0 count loaded");
    expect_item(2, 0, 32'h0000_0001, "R6 ch0 busy");

    wr(6'h04, 32'h0010_0100);
    wr(6'h0C, 32'h2800_0008);
    expect_item(0, 6'h08, 32'h0000_000C, "R6 queued descriptor waits");
    strobe(0, 2);
    expect_item(0, 6'h00, 32'h0010_0000, "R7 page carry on address");
    expect_item(0, 6'h08, 32'h0000_0004, "R7 count decrement");
    expect_item(4, 6'd0, 32'h0010_0000, "R7 word address output");
    strobe(0, 1);
    expect_item(0, 6'h00, 32'h0010_0100, "R9 chained address");
    expect_item(0, 6'h08, 32'h0000_0008, "R9 chained count");
    expect_item(2, 0, 32'h0000_0001, "R9 stays busy");
    expect_item(1, 0, 32'd1, "R11 irq raised");
    expect_item(0, 6'h0C, 32'hA800_0008, "R11 bit31 follows irq");

    wr(6'h0C, 32'h0800_0000);
    expect_item(1, 0, 32'd0, "R13 control write clears flag");
    expect_item(2, 0, 32'd0, "R8 disabled channel not busy");
    strobe(0, 1);
    expect_item(0, 6'h08, 32'h0000_0008, "R8 strobe ignored count");
    expect_item(0, 6'h00, 32'h0010_0100, "R8 strobe ignored address");

    wr(6'h0C, 32'h2000_0000);
    strobe(0, 2);
    expect_item(0, 6'h08, 32'h0000_0000, "R10 count zero at end");
    expect_item(2, 0, 32'd0, "R10 ch0 idle");
    expect_item(1, 0, 32'd0, "R12 no irq with enable clear");
    strobe(0, 1);
    expect_item(0, 6'h08, 32'h0000_0000, "R8 idle strobe ignored");
    strobe(2, 1);
    expect_item(0, 6'h28, 32'h0000_0000, "R8 ch2 idle strobe ignored");

    wr(6'h34, 32'h4000_0000);
    wr(6'h3C, 32'h2800_0004);
    @(negedge clk);
    expect_item(2, 0, 32'h0000_0008, "R6 ch3 busy");
    strobe(3, 1);
    expect_item(0, 6'h38, 32'h0000_0000, "R10 ch3 count zero");
    expect_item(0, 6'h30, 32'h4000_0004, "R7 ch3 address step");
    expect_item(2, 0, 32'd0, "R10 ch3 idle");
    expect_item(1, 0, 32'd1, "R11 ch3 irq");
    expect_item(0, 6'h3C, 32'hAA00_0004, "R11 R5 ch3 control readback");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule